// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block produces the frequency-offset word that steers a fractional-N divider or a digitally controlled oscillator. With it, a 50 MHz clock derived from a 25 MHz reference has its energy spread over a band, which lowers radiated emission peaks. The block runs on the reference clock. Once per reference cycle it produces a signed offset that traces a symmetric triangle. The triangle repeats at the 50 kHz modulation rate, so one profile period lasts 500 reference cycles.

A 4-bit select input chooses the spread shape and its depth, or turns spreading off. Bit 3 of the code gives the shape: 0 means spread centered on the nominal frequency, 1 means spread downward only. The all-ones code means no spread. An active-high power-on input gates the whole profile. While it is low the offset is held at zero, the profile phase is held at its start, and the block tells the output stage to put its drivers in tri-state. When the input returns high, the profile restarts from phase zero.

The offset LSB is 1/250 of 0.01 % of the nominal frequency. With this scale every point of the triangle is an exact integer, and the mean of a centered profile is exactly zero.

Top module: `ssc_profile_gen`

## Requirements
- R1: While reset is asserted, `offset_o` is 0 and `drive_en_o` is 0.
- R2: `spread_sel_i` and `pwr_on_i` each pass through a 2-stage synchronizer. `drive_en_o` follows `pwr_on_i` exactly 3 clock edges after an input change: unchanged after 2 edges, changed after the 3rd.
- R3: While the synchronized power-on is low, `offset_o` is 0. On the first enabled cycle, the profile restarts at phase 0 with the value -depth*250, using the currently selected code.
- R4: The profile period is 500 cycles, indexed by phase p = 0..499. With tri(p) = p for p < 250 and 500 - p otherwise, the offset at p is base + slope*tri(p). The extremes fall at p = 0 and p = 250.
- R5: Codes 0..7 (bit 3 = 0) give center spread of depth d = (code+1)*25 hundredths of a percent. The offset is d*(2*tri(p) - 250), swinging between -d*250 and +d*250. The offset summed over any full period is exactly 0.
- R6: Codes 8..14 (bit 3 = 1, not all ones) give down spread of depth d = (code-6)*25 hundredths of a percent, from 0.50 % to 2.00 %. The offset is d*(tri(p) - 250) and is never positive.
- R7: Code 15 (4'b1111) gives no spread: the offset stays 0 for as long as that code is active.
- R8: A change of the synchronized select code takes effect only at the next phase 0. Until then the running profile continues with the previous code.
- R9: Within a period (p ≠ 0), consecutive offsets differ by exactly the slope: 2*d for center spread, d for down spread, and 0 for no spread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | 25 MHz reference clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| spread_sel_i | input | 4 | Spread code: bit 3 shape, bits 2:0 depth, 4'b1111 off |
| pwr_on_i | input | 1 | High: run; low: power down, zero offset, outputs to tri-state |
| offset_o | output | OFS_W (18) | Signed offset, LSB = 0.01 % / 250 of nominal |
| drive_en_o | output | 1 | High when the clock output drivers should be enabled |

## Verification
The hardest situation to reach from the ports is a select change that lands mid-period and has to be deferred. The same applies to a power-down that cuts a period short and forces a restart. The bench has no view of the phase counter. It therefore keeps its own count of the phase from the synchronized inputs, then changes the code and drops power-on at arbitrary cycles inside a period. The scoreboard then demands that the old profile continue until phase 0, and that the restart begin at the negative extreme. A sweep through all sixteen codes, each held for two periods, covers every depth. It also yields at least one aligned full period per code, over which the centered mean is summed.

// File: rtl/ssc_prof_pkg.sv
package ssc_prof_pkg;

   localparam int SEL_W = 4;
   localparam logic [SEL_W-1:0] SEL_NO_SPREAD = 4'b1111;

   typedef enum logic [1:0] {
      KIND_FLAT   = 2'd0,
      KIND_CENTER = 2'd1,
      KIND_DOWN   = 2'd2
   } spread_kind_e;

endpackage

// File: rtl/ssc_in_sync.sv
module ssc_in_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic          clk_i,
   input  logic          rst_n_i,
   input  logic [W-1:0]  d_i,
   output logic [W-1:0]  q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] stg_q [STAGES];
         always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) begin
               for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
            end else begin
               stg_q[0] <= d_i;
               for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
            end
         end
         assign q_o = stg_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/ssc_depth_decode.sv
module ssc_depth_decode
   import ssc_prof_pkg::*;
#(
   parameter int STEP_HUND = 25,
   parameter int HALF      = 250,
   parameter int OFS_W     = 18
) (
   input  logic [SEL_W-1:0]         code_i,
   output spread_kind_e             kind_o,
   output logic signed [OFS_W-1:0]  depth_o,
   output logic signed [OFS_W-1:0]  base_o
);

   localparam logic signed [OFS_W-1:0] HALF_S = OFS_W'(HALF);
   localparam logic signed [OFS_W-1:0] UNIT_S = OFS_W'(STEP_HUND);

   logic [3:0] mult;

   always_comb begin
      kind_o = KIND_FLAT;
      mult   = 4'd0;
      if (code_i == SEL_NO_SPREAD) begin
         kind_o = KIND_FLAT;
         mult   = 4'd0;
      end else if (!code_i[SEL_W-1]) begin
         kind_o = KIND_CENTER;
         mult   = {1'b0, code_i[2:0]} + 4'd1;
      end else begin
         kind_o = KIND_DOWN;
         mult   = {1'b0, code_i[2:0]} + 4'd2;
      end
      depth_o = signed'(OFS_W'(mult)) * UNIT_S;
      base_o  = -(depth_o * HALF_S);
   end

endmodule

// File: rtl/ssc_phase_timer.sv
module ssc_phase_timer #(
   parameter int PERIOD = 500,
   parameter int PH_W   = 9
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             run_i,
   output logic [PH_W-1:0]  phase_o,
   output logic             load_o,
   output logic             rising_o
);

   localparam logic [PH_W-1:0] LAST_PH = PH_W'(PERIOD - 1);
   localparam logic [PH_W-1:0] HALF_PH = PH_W'(PERIOD / 2);

   logic primed_q;

   assign load_o   = run_i && (!primed_q || (phase_o == LAST_PH));
   assign rising_o = (phase_o < HALF_PH);

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         primed_q <= 1'b0;
         phase_o  <= '0;
      end else if (!run_i) begin
         primed_q <= 1'b0;
         phase_o  <= '0;
      end else if (load_o) begin
         primed_q <= 1'b1;
         phase_o  <= '0;
      end else begin
         phase_o  <= phase_o + 1'b1;
      end
   end

endmodule

// File: rtl/ssc_ramp_accum.sv
module ssc_ramp_accum
   import ssc_prof_pkg::*;
#(
   parameter int OFS_W = 18
) (
   input  logic                     clk_i,
   input  logic                     rst_n_i,
   input  logic                     run_i,
   input  logic                     load_i,
   input  logic                     rising_i,
   input  logic signed [OFS_W-1:0]  base_i,
   input  spread_kind_e             kind_i,
   input  logic signed [OFS_W-1:0]  depth_i,
   output logic signed [OFS_W-1:0]  acc_o
);

   logic signed [OFS_W-1:0] slope;

   always_comb begin
      slope = (kind_i == KIND_CENTER) ? (depth_i <<< 1) : depth_i;
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)      acc_o <= '0;
      else if (!run_i)   acc_o <= '0;
      else if (load_i)   acc_o <= base_i;
      else if (rising_i) acc_o <= acc_o + slope;
      else               acc_o <= acc_o - slope;
   end

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
   import ssc_prof_pkg::*;
#(
   parameter int REF_HZ      = 25_000_000,
   parameter int MOD_HZ      = 50_000,
   parameter int STEP_HUND   = 25,
   parameter int OFS_W       = 18,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk_ref_i,
   input  logic                     rst_n_i,
   input  logic [3:0]               spread_sel_i,
   input  logic                     pwr_on_i,
   output logic signed [OFS_W-1:0]  offset_o,
   output logic                     drive_en_o
);

   localparam int     PERIOD = REF_HZ / MOD_HZ;
   localparam int     HALF   = PERIOD / 2;
   localparam int     PH_W   = $clog2(PERIOD);
   localparam longint PEAK   = longint'(8 * STEP_HUND) * longint'(HALF);

   generate
      if (REF_HZ % MOD_HZ != 0) begin : g_bad_ratio
         $error("reference must be a whole multiple of the modulation rate");
      end
      if (PERIOD % 2 != 0 || PERIOD < 4) begin : g_bad_period
         $error("profile period must be even and at least 4 cycles");
      end
      if (PEAK >= (longint'(1) << (OFS_W - 1))) begin : g_bad_width
         $error("OFS_W too narrow for the deepest spread");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic [SEL_W:0]          raw_w, synced_w;
   logic [SEL_W-1:0]        sel_s;
   logic                    run_s;
   logic [PH_W-1:0]         phase_w;
   logic                    load_w, rising_w;
   spread_kind_e            kind_next, kind_q;
   logic signed [OFS_W-1:0] depth_next, depth_q, base_next;

   assign raw_w = {pwr_on_i, spread_sel_i};

   ssc_in_sync #(
      .W       (SEL_W + 1),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({1'b0, SEL_NO_SPREAD})
   ) sync_i (
      .clk_i   (clk_ref_i),
      .rst_n_i (rst_n_i),
      .d_i     (raw_w),
      .q_o     (synced_w)
   );

   assign sel_s = synced_w[SEL_W-1:0];
   assign run_s = synced_w[SEL_W];

   ssc_phase_timer #(
      .PERIOD (PERIOD),
      .PH_W   (PH_W)
   ) timer_i (
      .clk_i    (clk_ref_i),
      .rst_n_i  (rst_n_i),
      .run_i    (run_s),
      .phase_o  (phase_w),
      .load_o   (load_w),
      .rising_o (rising_w)
   );

   ssc_depth_decode #(
      .STEP_HUND (STEP_HUND),
      .HALF      (HALF),
      .OFS_W     (OFS_W)
   ) decode_i (
      .code_i  (sel_s),
      .kind_o  (kind_next),
      .depth_o (depth_next),
      .base_o  (base_next)
   );

   always_ff @(posedge clk_ref_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         kind_q     <= KIND_FLAT;
         depth_q    <= '0;
         drive_en_o <= 1'b0;
      end else begin
         drive_en_o <= run_s;
         if (!run_s) begin
            kind_q  <= KIND_FLAT;
            depth_q <= '0;
         end else if (load_w) begin
            kind_q  <= kind_next;
            depth_q <= depth_next;
         end
      end
   end

   ssc_ramp_accum #(
      .OFS_W (OFS_W)
   ) accum_i (
      .clk_i    (clk_ref_i),
      .rst_n_i  (rst_n_i),
      .run_i    (run_s),
      .load_i   (load_w),
      .rising_i (rising_w),
      .base_i   (base_next),
      .kind_i   (kind_q),
      .depth_i  (depth_q),
      .acc_o    (offset_o)
   );

endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk
   import ssc_prof_pkg::*;
#(
   parameter int OFS_W  = 18,
   parameter int PH_W   = 9,
   parameter int PERIOD = 500
) (
   input logic                     clk_i,
   input logic                     rst_n_i,
   input logic signed [OFS_W-1:0]  offset_i,
   input logic                     en_i,
   input spread_kind_e             kind_i,
   input logic signed [OFS_W-1:0]  depth_i,
   input logic [PH_W-1:0]          phase_i
);

   localparam int HALF = PERIOD / 2;

   function automatic longint mag(input longint v);
      return (v < 0) ? -v : v;
   endfunction

   // R3: no offset while drivers are off
   assert_dark_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !en_i |-> (offset_i == '0));

   // R7: flat profile holds zero
   assert_flat_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (kind_i == KIND_FLAT) |-> (offset_i == '0));

   // R6: down spread never above nominal
   assert_down_nonpos_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (kind_i == KIND_DOWN) |-> (offset_i <= 0));

   // R5: center spread bounded by +/- depth*HALF
   assert_center_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (kind_i == KIND_CENTER) |-> (mag(longint'(offset_i)) <= longint'(depth_i) * HALF));

   // R8: the active code only changes at phase 0
   assert_select_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (phase_i != '0) |-> ($stable(kind_i) && $stable(depth_i)));

   // R9: exact slope between consecutive samples inside a period
   assert_slope_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (en_i && (phase_i != '0)) |->
         (mag(longint'(offset_i) - longint'($past(offset_i))) ==
          ((kind_i == KIND_CENTER) ? 2 * longint'(depth_i) : longint'(depth_i))));

   // R4: phase stays within one period
   assert_phase_range_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      phase_i < PH_W'(PERIOD));

endmodule

bind ssc_profile_gen ssc_profile_chk #(
   .OFS_W  (OFS_W),
   .PH_W   (PH_W),
   .PERIOD (PERIOD)
) chk_i (
   .clk_i    (clk_ref_i),
   .rst_n_i  (rst_n_i),
   .offset_i (offset_o),
   .en_i     (drive_en_o),
   .kind_i   (kind_q),
   .depth_i  (depth_q),
   .phase_i  (phase_w)
);

// File: tb/ssc_profile_gen_tb_top.sv
module ssc_profile_gen_tb_top;

   localparam int OFS_W  = 18;
   localparam int SYNC   = 2;
   localparam int PERIOD = 500;
   localparam int HALF   = 250;

   typedef struct {
      int val;
      bit en;
      int code;
      int ph;
      bit primed;
      bit pend;
      bit restart;
      bit in_rst;
   } exp_t;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [3:0]              sel = 4'hF;
   logic                    pwr = 1'b1;
   logic signed [OFS_W-1:0] offset;
   logic                    drive_en;

   int n_checks = 0;
   int n_err    = 0;
   bit done     = 1'b0;

   exp_t q[$];

   always #4 clk = ~clk;

   ssc_profile_gen #(.OFS_W(OFS_W), .SYNC_STAGES(SYNC)) dut_i (
      .clk_ref_i    (clk),
      .rst_n_i      (rst_n),
      .spread_sel_i (sel),
      .pwr_on_i     (pwr),
      .offset_o     (offset),
      .drive_en_o   (drive_en)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int depth_of(input int c);
      if (c == 15) return 0;
      if (c < 8) return (c + 1) * 25;
      return (c - 6) * 25;
   endfunction

   function automatic int slope_of(input int c);
      return (c < 8) ? 2 * depth_of(c) : depth_of(c);
   endfunction

   function automatic int profile(input int c, input int p);
      int t;
      t = (p < HALF) ? p : PERIOD - p;
      if (c == 15) return 0;
      if (c < 8) return depth_of(c) * (2 * t - HALF);
      return depth_of(c) * (t - HALF);
   endfunction

   // driver side: reference model of the requirements, pushes one item per edge
   int ssel [SYNC];
   bit srun [SYNC];
   int m_code = 15, m_ph = 0;
   bit m_primed = 0, m_en = 0;

   always @(posedge clk) begin
      exp_t e;
      bit   run_s, rs;
      int   sel_s;
      rs = 1'b0;
      e.in_rst = !rst_n;
      if (!rst_n) begin
         for (int i = 0; i < SYNC; i++) begin ssel[i] = 15; srun[i] = 1'b0; end
         m_primed = 1'b0; m_ph = 0; m_code = 15; m_en = 1'b0;
      end else begin
         run_s = srun[SYNC-1];
         sel_s = ssel[SYNC-1];
         if (!run_s) begin
            m_primed = 1'b0; m_ph = 0; m_code = 15;
         end else if (!m_primed || m_ph == PERIOD - 1) begin
            rs = !m_primed;
            m_primed = 1'b1; m_ph = 0; m_code = sel_s;
         end else begin
            m_ph++;
         end
         m_en = run_s;
         for (int i = SYNC - 1; i > 0; i--) begin ssel[i] = ssel[i-1]; srun[i] = srun[i-1]; end
         ssel[0] = int'(sel);
         srun[0] = pwr;
      end
      e.en      = m_en;
      e.code    = m_code;
      e.ph      = m_ph;
      e.primed  = m_primed;
      e.restart = rs;
      e.pend    = m_primed && (ssel[SYNC-1] != m_code);
      e.val     = m_primed ? profile(m_code, m_ph) : 0;
      q.push_back(e);
   end

   // monitor side: pops expected items and compares away from the edge
   int     prev_val = 0;
   bit     prev_ok  = 0;
   longint sum      = 0;
   bit     track    = 0;

   always @(negedge clk) begin
      if (q.size() != 0) begin
         exp_t  e;
         string tag;
         int    act;
         e   = q.pop_front();
         act = int'(offset);
         if (e.in_rst)                    tag = "R1";
         else if (!e.en || e.restart)     tag = "R3";
         else if (e.code == 15)           tag = "R7";
         else if (e.pend)                 tag = "R8";
         else if (e.ph == 0 || e.ph == HALF) tag = "R4";
         else if (e.code >= 8)            tag = "R6";
         else                             tag = "R5";
         chk(drive_en == e.en, e.in_rst ? "R1" : "R2", "drive enable", drive_en, e.en);
         chk(act == e.val, tag, "offset", act, e.val);
         if (e.primed && prev_ok && e.ph != 0) begin
            int d;
            d = (act > prev_val) ? act - prev_val : prev_val - act;
            chk(d == slope_of(e.code), "R9", "slope", d, slope_of(e.code));
         end
         if (!e.primed) track = 1'b0;
         else if (e.ph == 0) begin sum = act; track = (e.code < 8); end
         else sum += act;
         if (e.primed && e.ph == PERIOD - 1 && track) begin
            chk(sum == 0, "R5", "period mean", sum, 0);
            track = 1'b0;
         end
         prev_val = act;
         prev_ok  = e.primed;
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      cycles(3);
      chk(offset == '0, "R1", "offset in reset", offset, 0);
      chk(drive_en == 1'b0, "R1", "enable in reset", drive_en, 0);
      rst_n = 1'b1;
      cycles(600);                       // R7: default no-spread code
      chk(offset == '0, "R7", "flat offset", offset, 0);
      // R2: enable latency of SYNC+1 edges
      pwr = 1'b0;
      repeat (SYNC) @(posedge clk);
      #1 chk(drive_en == 1'b1, "R2", "enable before sync", drive_en, 1);
      @(posedge clk);
      #1 chk(drive_en == 1'b0, "R2", "enable after sync", drive_en, 0);
      cycles(20);
      pwr = 1'b1;
      cycles(20);
      // every code for two periods
      for (int c = 0; c < 16; c++) begin
         sel = 4'(c);
         cycles(1010);
      end
      // R8: mid-period change deferred
      sel = 4'h7;
      cycles(700);
      sel = 4'h0;
      cycles(37);
      sel = 4'hA;
      cycles(600);
      // R3: power-down inside a period, then restart
      pwr = 1'b0;
      cycles(60);
      sel = 4'h3;
      pwr = 1'b1;
      cycles(700);
      done = 1'b1;
      cycles(3);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_err++;
         $display("FAIL R4 watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end

endmodule